// File: doc/BRIEF.md
# Configuration Write Guard with Init Handshake

This block protects the configuration registers of a real-time clock. Software must write a two-byte key, in order, to a key register before any other register accepts a write. Any other key value locks the registers again. Calendar values, the 12/24-hour format bit and the prescaler dividers need a second condition as well. Software sets an init request bit. The request crosses into the slow RTC clock domain and puts the clock core into its initialization state. The acknowledgement then crosses back, and a read-only ready flag rises.

Software unlocks the block, sets the init bit and polls the ready flag. It then loads the calendar and divider registers, clears the init bit and writes a lock value to the key register. The counters downstream read the configuration outputs. They stop counting while `core_init` is high.

Top module: `rtc_wprot_top`

## Requirements
- R1: Writing 0xCA and then 0x53 to the low byte of the key register (address 0) unlocks the block from the next bus cycle. STATUS bit 1 then reads 1.
- R2: While unlocked, writing any key value other than 0xCA or 0x53 (for example 0xFF) locks the block from the next cycle.
- R3: A wrong second key, or 0x53 written without 0xCA before it, leaves the block locked. Writing 0xCA in any state starts a fresh sequence and leaves the block locked. Writes to other addresses do not disturb a sequence in progress.
- R4: The key register accepts a write in every state and always reads 0.
- R5: While locked, writes to CTRL, PRESC, TIME and DATE are ignored, and their readback is unchanged.
- R6: While unlocked, writing CTRL bit 0 = 1 sets the init request. `core_init` rises on the second `rtc_clk` rising edge after the request register changes. STATUS bit 0 (ready) rises two bus clocks after that.
- R7: Clearing CTRL bit 0 lowers `core_init` on the second `rtc_clk` edge afterwards. The ready flag falls two bus clocks after that.
- R8: PRESC, TIME, DATE and CTRL bit 1 (12-hour format) take a write only when the block is unlocked, the ready flag is 1 and the init request is 1. Otherwise they keep their values.
- R9: After reset the block is locked and the init request, ready flag, format bit, TIME and DATE are all 0. The prescaler divider is 255 and the asynchronous prescaler is 127.
- R10: Reads are combinational while `rd_en` is 1, and read 0 when `rd_en` is 0. The map is: 1 CTRL {bit1 format, bit0 init request}; 2 STATUS {bit1 unlocked, bit0 ready}; 3 PRESC {asynchronous divider at [22:16], divider at [14:0]}; 4 TIME; 5 DATE. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rtc_clk | input | 1 | Slow RTC core clock |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| core_init | output | 1 | Core is in initialization state (RTC domain) |
| cfg_fmt12 | output | 1 | 12-hour format selected |
| cfg_presc_sync | output | SYNC_W | Divider value |
| cfg_presc_async | output | ASYNC_W | Asynchronous prescaler value |
| cfg_time | output | 32 | Time value |
| cfg_date | output | 32 | Date value |

## Verification
The assertions assume that the bus inputs change only away from rising edges of `clk`. They also assume that reset is released away from the edges of either clock. The timing claims also assume that the init bit stays at one level longer than a full request and acknowledge round trip. The bench changes inputs only on falling bus edges. It offsets `rtc_clk` so that none of its edges meets a bus edge. After each init toggle it polls the ready flag until the flag settles before making the next change.

// File: rtl/rwp_pkg.sv
package rwp_pkg;
  localparam int ADDR_W   = 3;
  localparam int BUS_W    = 32;
  localparam int ASYNC_LSB = 16;

  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

  localparam logic [ADDR_W-1:0] A_KEY   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PRESC = 3'd3;
  localparam logic [ADDR_W-1:0] A_TIME  = 3'd4;
  localparam logic [ADDR_W-1:0] A_DATE  = 3'd5;

  typedef enum logic [1:0] {KS_LOCKED, KS_FIRST, KS_OPEN} key_state_e;

  // next key state for one key-register write
  function automatic key_state_e key_step(key_state_e cur, logic [7:0] b);
    if (b == KEY_FIRST) return KS_FIRST;
    if (b == KEY_SECOND && cur == KS_FIRST) return KS_OPEN;
    return KS_LOCKED;
  endfunction
endpackage

// File: rtl/rwp_key_fsm.sv
module rwp_key_fsm
  import rwp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output key_state_e state_q,
  output logic       unlocked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= KS_LOCKED;
    else if (key_wr) state_q <= key_step(state_q, key_byte);
  end

  assign unlocked = (state_q == KS_OPEN);
endmodule

// File: rtl/rwp_sync_chain.sv
module rwp_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rwp_init_handshake.sv
module rwp_init_handshake #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rtc_clk,
  input  logic rst_n,
  input  logic init_req,
  output logic core_init,
  output logic init_ready
);
  // request into the RTC domain; the last stage is the core init state
  rwp_sync_chain #(.STAGES(STAGES)) u_fwd (
    .clk(rtc_clk), .rst_n(rst_n), .d(init_req), .q(core_init)
  );

  // acknowledge back into the bus domain
  rwp_sync_chain #(.STAGES(STAGES)) u_back (
    .clk(clk), .rst_n(rst_n), .d(core_init), .q(init_ready)
  );
endmodule

// File: rtl/rwp_cfg_regs.sv
module rwp_cfg_regs
  import rwp_pkg::*;
#(
  parameter int SYNC_W    = 15,
  parameter int ASYNC_W   = 7,
  parameter int SYNC_RST  = 255,
  parameter int ASYNC_RST = 127
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BUS_W-1:0]   wdata,
  input  logic               unlocked,
  input  logic               init_ready,
  output logic               init_req,
  output logic               fmt12,
  output logic [SYNC_W-1:0]  presc_sync,
  output logic [ASYNC_W-1:0] presc_async,
  output logic [BUS_W-1:0]   time_q,
  output logic [BUS_W-1:0]   date_q,
  output logic               cal_open
);
  logic prot_ok;

  assign prot_ok  = wr_en & unlocked;
  assign cal_open = unlocked & init_ready & init_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_req <= 1'b0;
      fmt12    <= 1'b0;
    end else if (prot_ok && addr == A_CTRL) begin
      init_req <= wdata[0];
      if (cal_open) fmt12 <= wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_sync  <= SYNC_W'(SYNC_RST);
      presc_async <= ASYNC_W'(ASYNC_RST);
    end else if (prot_ok && cal_open && addr == A_PRESC) begin
      presc_sync  <= wdata[SYNC_W-1:0];
      presc_async <= wdata[ASYNC_LSB +: ASYNC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      date_q <= '0;
    end else if (prot_ok && cal_open) begin
      if (addr == A_TIME) time_q <= wdata;
      if (addr == A_DATE) date_q <= wdata;
    end
  end
endmodule

// File: rtl/rtc_wprot_top.sv
module rtc_wprot_top
  import rwp_pkg::*;
#(
  parameter int SYNC_W      = 15,
  parameter int ASYNC_W     = 7,
  parameter int SYNC_RST    = 255,
  parameter int ASYNC_RST   = 127,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rtc_clk,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [2:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               core_init,
  output logic               cfg_fmt12,
  output logic [SYNC_W-1:0]  cfg_presc_sync,
  output logic [ASYNC_W-1:0] cfg_presc_async,
  output logic [31:0]        cfg_time,
  output logic [31:0]        cfg_date
);
  // named internal events for the checker
  logic       ev_key_wr;
  logic       unlocked;
  logic       init_req;
  logic       init_ready;
  logic       cal_open;
  key_state_e key_state;

  assign ev_key_wr = wr_en && (addr == A_KEY);

  function automatic logic [BUS_W-1:0] presc_word(logic [SYNC_W-1:0] s,
                                                  logic [ASYNC_W-1:0] a);
    logic [BUS_W-1:0] w;
    w = '0;
    w[SYNC_W-1:0] = s;
    w[ASYNC_LSB +: ASYNC_W] = a;
    return w;
  endfunction

  rwp_key_fsm u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(ev_key_wr), .key_byte(wdata[7:0]),
    .state_q(key_state), .unlocked(unlocked)
  );

  rwp_init_handshake #(.STAGES(SYNC_STAGES)) u_hs (
    .clk(clk), .rtc_clk(rtc_clk), .rst_n(rst_n), .init_req(init_req),
    .core_init(core_init), .init_ready(init_ready)
  );

  rwp_cfg_regs #(
    .SYNC_W(SYNC_W), .ASYNC_W(ASYNC_W),
    .SYNC_RST(SYNC_RST), .ASYNC_RST(ASYNC_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .unlocked(unlocked), .init_ready(init_ready), .init_req(init_req),
    .fmt12(cfg_fmt12), .presc_sync(cfg_presc_sync),
    .presc_async(cfg_presc_async), .time_q(cfg_time), .date_q(cfg_date),
    .cal_open(cal_open)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL:  rdata = {30'b0, cfg_fmt12, init_req};
        A_STAT:  rdata = {30'b0, unlocked, init_ready};
        A_PRESC: rdata = presc_word(cfg_presc_sync, cfg_presc_async);
        A_TIME:  rdata = cfg_time;
        A_DATE:  rdata = cfg_date;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rwp_checker.sv
module rwp_checker
  import rwp_pkg::*;
#(
  parameter int SYNC_W  = 15,
  parameter int ASYNC_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [2:0]         addr,
  input logic [7:0]         key_byte,
  input logic               ev_key_wr,
  input key_state_e         key_state,
  input logic               unlocked,
  input logic               init_req,
  input logic               init_ready,
  input logic [SYNC_W-1:0]  presc_sync,
  input logic [ASYNC_W-1:0] presc_async,
  input logic [31:0]        time_q
);
  assert_unlock_seq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_key_wr && key_byte == KEY_SECOND && key_state == KS_FIRST) |=> unlocked);

  assert_relock_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_key_wr && key_byte == 8'hFF) |=> !unlocked);

  assert_bad_key_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_key_wr && key_byte != KEY_FIRST &&
     !(key_byte == KEY_SECOND && key_state == KS_FIRST)) |=> !unlocked);

  assert_locked_presc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked && addr == A_PRESC) |=>
      ($stable(presc_sync) && $stable(presc_async)));

  assert_locked_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked && addr == A_CTRL) |=> $stable(init_req));

  assert_time_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_TIME && !init_ready) |=> $stable(time_q));
endmodule

bind rtc_wprot_top rwp_checker #(.SYNC_W(SYNC_W), .ASYNC_W(ASYNC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .key_byte(wdata[7:0]),
  .ev_key_wr(ev_key_wr), .key_state(key_state), .unlocked(unlocked),
  .init_req(init_req), .init_ready(init_ready), .presc_sync(cfg_presc_sync),
  .presc_async(cfg_presc_async), .time_q(cfg_time)
);

// File: tb/test_rtc_wprot_top.sv
`timescale 1ns/1ps
module test_rtc_wprot_top;
  logic        clk = 0, rtc_clk = 0, rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        core_init, cfg_fmt12;
  logic [14:0] cfg_presc_sync;
  logic [6:0]  cfg_presc_async;
  logic [31:0] cfg_time, cfg_date;

  int compared = 0, mismatched = 0;
  bit done = 0;

  rtc_wprot_top i_rtc_wprot_top (
    .clk(clk), .rst_n(rst_n), .rtc_clk(rtc_clk), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .core_init(core_init),
    .cfg_fmt12(cfg_fmt12), .cfg_presc_sync(cfg_presc_sync),
    .cfg_presc_async(cfg_presc_async), .cfg_time(cfg_time), .cfg_date(cfg_date)
  );

  always #10 clk = ~clk;              // 50 MHz bus clock
  initial begin #3; forever #35 rtc_clk = ~rtc_clk; end

  // ---------------- behavioural reference model ----------------
  int        m_key;                   // 0 locked, 1 first byte seen, 2 open
  bit        m_req, m_fmt;
  bit [14:0] m_sync;
  bit [6:0]  m_async;
  bit [31:0] m_time, m_date;
  bit        rtc_q[$];                // request samples in RTC domain
  bit        bus_q[$];                // acknowledge samples in bus domain
  bit        m_core, m_ready;

  always @(posedge rtc_clk or negedge rst_n) begin
    if (!rst_n) begin rtc_q = {}; m_core = 0; end
    else begin
      rtc_q.push_back(m_req);
      if (rtc_q.size() > 2) void'(rtc_q.pop_front());
      m_core = (rtc_q.size() == 2) ? rtc_q[0] : 1'b0;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_key = 0; m_req = 0; m_fmt = 0; m_sync = 255; m_async = 127;
      m_time = 0; m_date = 0; bus_q = {}; m_ready = 0;
    end else begin
      bit gate;
      gate = (m_key == 2) && m_ready && m_req;
      if (wr_en) begin
        if (addr == 0) begin
          if (wdata[7:0] == 8'hCA) m_key = 1;
          else m_key = (wdata[7:0] == 8'h53 && m_key == 1) ? 2 : 0;
        end else if (m_key == 2 || (addr != 1 && 0)) begin
          if (addr == 1) begin if (gate) m_fmt = wdata[1]; m_req = wdata[0]; end
          if (addr == 3 && gate) begin m_sync = wdata[14:0]; m_async = wdata[22:16]; end
          if (addr == 4 && gate) m_time = wdata;
          if (addr == 5 && gate) m_date = wdata;
        end
      end
      bus_q.push_back(m_core);
      if (bus_q.size() > 2) void'(bus_q.pop_front());
      m_ready = (bus_q.size() == 2) ? bus_q[0] : 1'b0;
    end
  end

  function automatic logic [31:0] m_read(logic r, logic [2:0] a);
    if (!r) return 0;
    case (a)
      1: return {30'b0, m_fmt, m_req};
      2: return {30'b0, (m_key == 2), m_ready};
      3: return {9'b0, m_async, 1'b0, m_sync};
      4: return m_time;
      5: return m_date;
      default: return 0;
    endcase
  endfunction

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // every-cycle comparison, sampled 5 ns after the bus edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      cmp("R6", "core_init", {31'b0, core_init}, {31'b0, m_core});
      cmp("R8", "fmt12", {31'b0, cfg_fmt12}, {31'b0, m_fmt});
      cmp("R8", "presc_sync", {17'b0, cfg_presc_sync}, {17'b0, m_sync});
      cmp("R8", "presc_async", {25'b0, cfg_presc_async}, {25'b0, m_async});
      cmp("R8", "time", cfg_time, m_time);
      cmp("R8", "date", cfg_date, m_date);
      cmp("R10", "rdata", rdata, m_read(rd_en, addr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); rd_en = 0; wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); wr_en = 0; rd_en = 1; addr = a; #2 v = rdata;
  endtask

  task automatic wait_ready(bit val, string req);
    logic [31:0] v;
    v = 0;
    for (int i = 0; i < 40; i++) begin
      rd(2, v);
      if (v[0] == val) break;
    end
    cmp(req, "ready settles", {31'b0, v[0]}, {31'b0, val});
  endtask

  initial begin
    logic [31:0] v;
    #105 rst_n = 1;
    repeat (2) @(negedge clk);

    // R9 reset state
    rd(2, v); cmp("R9", "status after reset", v, 0);
    rd(3, v); cmp("R9", "presc after reset", v, {9'b0, 7'd127, 1'b0, 15'd255});
    rd(4, v); cmp("R9", "time after reset", v, 0);
    rd(1, v); cmp("R9", "ctrl after reset", v, 0);

    // R5 locked writes ignored
    wr(3, 32'h0012_0034); rd(3, v); cmp("R5", "presc locked", v, {9'b0, 7'd127, 1'b0, 15'd255});
    wr(1, 32'h3);         rd(1, v); cmp("R5", "ctrl locked", v, 0);
    wr(4, 32'hDEAD_BEEF); rd(4, v); cmp("R5", "time locked", v, 0);

    // R3 bad sequences
    wr(0, 32'hCA); wr(0, 32'h11); wr(0, 32'h53); rd(2, v); cmp("R3", "wrong second key", v[1], 0);
    wr(0, 32'h53); rd(2, v); cmp("R3", "0x53 alone", v[1], 0);
    wr(0, 32'hCA); rd(2, v); cmp("R3", "after first key only", v[1], 0);
    // R4 key reads zero
    rd(0, v); cmp("R4", "key readback", v, 0);
    // R1 repeated first key, then second key; other writes in between are harmless
    wr(0, 32'hCA); wr(4, 32'h5); wr(0, 32'h53); rd(2, v); cmp("R1", "unlocked", v[1], 1);

    // R8 unlocked but not in init
    wr(3, 32'h0005_0007); rd(3, v); cmp("R8", "presc no init", v, {9'b0, 7'd127, 1'b0, 15'd255});
    wr(1, 32'h2); rd(1, v); cmp("R8", "fmt no init", v, 0);

    // R6 enter init
    wr(1, 32'h1);
    wait_ready(1, "R6");
    cmp("R6", "core_init high", {31'b0, core_init}, 1);

    // R8 / R10 loads in init
    wr(3, 32'h0042_1234); rd(3, v); cmp("R8", "presc load", v, 32'h0042_1234);
    wr(4, 32'h0012_3456); rd(4, v); cmp("R8", "time load", v, 32'h0012_3456);
    wr(5, 32'h0024_0131); rd(5, v); cmp("R10", "date load", v, 32'h0024_0131);
    wr(1, 32'h3); rd(1, v); cmp("R8", "fmt load", v, 32'h3);
    rd(6, v); cmp("R10", "unmapped", v, 0);

    // R7 leave init
    wr(1, 32'h2);
    wait_ready(0, "R7");
    cmp("R7", "core_init low", {31'b0, core_init}, 0);
    wr(4, 32'h1); rd(4, v); cmp("R8", "time after init exit", v, 32'h0012_3456);

    // R2 lock again
    wr(0, 32'hFF); rd(2, v); cmp("R2", "relocked", v[1], 0);
    wr(1, 32'h1); rd(1, v); cmp("R2", "ctrl ignored after relock", v, 32'h2);
    // R4 key still writable while locked
    wr(0, 32'hCA); wr(0, 32'h53); rd(2, v); cmp("R4", "unlock again", v[1], 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule